// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Aligner

This unit sits between a processor's memory stage and a word-wide data memory. For each request it forms the effective address from a base value and a signed 16-bit displacement. For stores it steers the source register's low byte, low halfword or full word onto the memory write lanes and raises only the matching byte enables. For loads it remembers the access shape for one cycle. When the memory word comes back, it pulls out the addressed byte, halfword or word and widens it to the full width, with either sign fill or zero fill.

Byte order inside a memory word is big-endian: the byte at the lowest address is the most significant one. Halfword accesses that straddle a halfword boundary, and word accesses that are not on a 4-byte boundary, are reported on a misalignment flag. Such an access writes nothing and returns no load result.

Top module: `lsu_lane_unit`

## Requirements
- R1: `mem_addr` equals `base_addr` plus `req_offset` sign-extended from 16 bits, modulo 2^32, in the same cycle.
- R2: Size codes on `req_size` are 00 byte, 01 halfword and 1x word. `misalign` is high exactly when `req_valid` is high and either a halfword has address bit 0 set or a word has address bits 1:0 non-zero. A byte access is never misaligned.
- R3: During a misaligned access `mem_be` is 0000, and `ld_valid` stays low in the following cycle.
- R4: `mem_be[3]` enables bits 31:24 and `mem_be[0]` enables bits 7:0. For an aligned store, a byte at offset k (address bits 1:0) gives 4'b1000 >> k, a halfword gives 4'b1100 at offset 0 and 4'b0011 at offset 2, and a word gives 4'b1111. Loads and idle cycles give 0000.
- R5: For an aligned store, `mem_wdata` carries `store_data[7:0]` on all four byte lanes for a byte, and `store_data[15:0]` on both halves for a halfword. For a word it carries `store_data` unchanged.
- R6: A loaded byte at offset k is taken from `mem_rdata[31-8k -: 8]`. A loaded halfword is taken from bits 31:16 at offset 0 and bits 15:0 at offset 2. A loaded word is `mem_rdata` unchanged.
- R7: With `req_unsigned` low, byte and halfword load results copy their top bit into every higher bit of `ld_data`.
- R8: With `req_unsigned` high, byte and halfword load results have every higher bit of `ld_data` cleared. Word loads ignore the flag.
- R9: `ld_valid` is high in the cycle after an aligned load request and low otherwise. In that cycle `ld_data` is formed from that cycle's `mem_rdata`, and otherwise `ld_data` is zero.
- R10: While `rst_n` is low at a rising edge, the next cycle has `ld_valid` low, even if a load was requested in the same cycle.
- R11: Size code 11 behaves exactly like word (10) for alignment, enables, write data and load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_unsigned | input | 1 | Zero-fill sub-word load results |
| base_addr | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| store_data | input | 32 | Store source register |
| mem_addr | output | 32 | Effective byte address |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_be | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| misalign | output | 1 | Current access is misaligned |
| mem_rdata | input | 32 | Memory word returned one cycle after a load |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned, extended load result |

## Verification
The sweep crosses every size code, both fill modes, loads and stores, and all four low address values. Base and displacement pairs are chosen so that negative displacements and wrap-around of the 32-bit sum occur. A lane order mirrored to little-endian would return bytes from the wrong end of the word. Enable masks shifted the wrong way would be caught on offsets 1 and 3. Memory words rotate between accesses so that every lane carries both a set and a clear top bit, which exposes a sign taken from the wrong bit or a fill mode that is swapped or ignored. Misaligned halfwords and words are checked so that no write lane and no load result slips through. A request made in the same cycle as reset must not produce a result.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // number of bytes an access of the given size code covers
  function automatic int access_bytes(logic [1:0] size, int word_bytes);
    case (size)
      SZ_BYTE: access_bytes = 1;
      SZ_HALF: access_bytes = 2;
      default: access_bytes = word_bytes;
    endcase
  endfunction

  // alignment rule: offset must be a multiple of the access size
  function automatic logic is_misaligned(logic [1:0] size, int lane_off, int word_bytes);
    int nb;
    nb = access_bytes(size, word_bytes);
    is_misaligned = (lane_off % nb) != 0;
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [LANE_W-1:0] lane_off,
  output logic              misal
);
  localparam int NBYTES = 1 << LANE_W;
  localparam int EXT_W  = ADDR_W - OFF_W;

  assign eff_addr = base + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign lane_off = eff_addr[LANE_W-1:0];
  assign misal    = is_misaligned(size, int'(lane_off), NBYTES);
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0]   src,
  input  logic [1:0]          size,
  input  logic [LANE_W-1:0]   lane_off,
  input  logic                enable,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] be
);
  localparam int NBYTES = DATA_W / 8;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    // big-endian position of this lane inside the word
    localparam int POS = NBYTES - 1 - i;
    always_comb begin
      int nb;
      int off;
      nb  = access_bytes(size, NBYTES);
      off = int'(lane_off);
      wdata[i*8 +: 8] = src[(i % nb)*8 +: 8];
      be[i] = enable && (POS >= off) && (POS < off + nb);
    end
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        size,
  input  logic              uns,
  input  logic [LANE_W-1:0] lane_off,
  output logic [DATA_W-1:0] data
);
  localparam int NBYTES = DATA_W / 8;

  always_comb begin
    int nb;
    int off;
    logic [DATA_W-1:0] raw;
    logic sbit;
    nb  = access_bytes(size, NBYTES);
    off = int'(lane_off);
    raw = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (k < nb && off + k < NBYTES)
        raw[(nb-1-k)*8 +: 8] = rdata[(NBYTES-1-off-k)*8 +: 8];
    end
    sbit = raw[nb*8-1];
    data = raw;
    for (int b = 0; b < DATA_W; b++) begin
      if (b >= nb*8) data[b] = sbit & ~uns;
    end
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic [1:0]          req_size,
  input  logic                req_unsigned,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [DATA_W-1:0]   store_data,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  output logic                misalign,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                ld_valid,
  output logic [DATA_W-1:0]   ld_data
);
  localparam int NBYTES = DATA_W / 8;
  localparam int LANE_W = $clog2(NBYTES);

  logic [LANE_W-1:0] lane_off;
  logic              addr_misal;
  logic              store_accept;
  logic              load_accept;
  logic              ld_pend;
  logic [LANE_W-1:0] ld_off;
  logic [1:0]        ld_size;
  logic              ld_uns;
  logic [DATA_W-1:0] aligned;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_addr (
    .base     (base_addr),
    .offset   (req_offset),
    .size     (req_size),
    .eff_addr (mem_addr),
    .lane_off (lane_off),
    .misal    (addr_misal)
  );

  assign misalign     = req_valid && addr_misal;
  assign store_accept = req_valid && req_store && !addr_misal;
  assign load_accept  = req_valid && !req_store && !addr_misal;

  lsu_store_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_store (
    .src      (store_data),
    .size     (req_size),
    .lane_off (lane_off),
    .enable   (store_accept),
    .wdata    (mem_wdata),
    .be       (mem_be)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_pend <= 1'b0;
      ld_off  <= '0;
      ld_size <= SZ_BYTE;
      ld_uns  <= 1'b0;
    end else begin
      ld_pend <= load_accept;
      if (load_accept) begin
        ld_off  <= lane_off;
        ld_size <= req_size;
        ld_uns  <= req_unsigned;
      end
    end
  end

  lsu_load_align #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_load (
    .rdata    (mem_rdata),
    .size     (ld_size),
    .uns      (ld_uns),
    .lane_off (ld_off),
    .data     (aligned)
  );

  assign ld_valid = ld_pend;
  assign ld_data  = ld_pend ? aligned : '0;
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_store,
  input logic [1:0]          req_size,
  input logic                req_unsigned,
  input logic [DATA_W/8-1:0] mem_be,
  input logic                misalign,
  input logic                ld_valid,
  input logic [DATA_W-1:0]   ld_data
);
  localparam int NBYTES = DATA_W / 8;

  assert_misalign_be_R3: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> mem_be == '0);

  assert_misalign_no_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && misalign) |=> !ld_valid);

  assert_load_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !misalign) |=> ld_valid);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_store) |=> !ld_valid);

  assert_byte_never_misal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == SZ_BYTE) |-> !misalign);

  assert_be_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !misalign) |->
      ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == NBYTES));

  assert_be_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_store) |-> mem_be == '0);

  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(req_unsigned) && $past(req_size) == SZ_BYTE) |->
      ld_data[DATA_W-1:8] == '0);

  assert_sign_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !$past(req_unsigned) && $past(req_size) == SZ_HALF) |->
      ld_data[DATA_W-1:16] == {(DATA_W-16){ld_data[15]}});

  assert_idle_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> ld_data == '0);
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_store    (req_store),
  .req_size     (req_size),
  .req_unsigned (req_unsigned),
  .mem_be       (mem_be),
  .misalign     (misalign),
  .ld_valid     (ld_valid),
  .ld_data      (ld_data)
);

// File: tb/tb_lsu_lane_unit.sv
module tb_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_unsigned = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] store_data = '0;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        misalign;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid;
  logic [31:0] ld_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lsu_lane_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base_addr(base_addr),
    .req_offset(req_offset), .store_data(store_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .misalign(misalign),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(logic [31:0] x, int s);
    return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
  endfunction

  task automatic access(bit st, logic [1:0] sz, bit uns, logic [31:0] base,
                        logic [15:0] offs, logic [31:0] src, logic [31:0] rd);
    logic [31:0] ea, exp_ld, exp_wd, v;
    logic [3:0]  exp_be;
    logic [1:0]  k;
    bit mis, word;
    string rq;
    ea   = base + {{16{offs[15]}}, offs};
    k    = ea[1:0];
    word = sz[1];
    mis  = (sz == 2'b01) ? k[0] : (word ? (k != 2'b00) : 1'b0);
    rq   = (sz == 2'b11) ? "R11" : "R4";
    exp_be = 4'b0000;
    exp_wd = src;
    if (st && !mis) begin
      if (sz == 2'b00) begin exp_be = 4'b1000 >> k; exp_wd = {4{src[7:0]}}; end
      else if (sz == 2'b01) begin exp_be = k[1] ? 4'b0011 : 4'b1100; exp_wd = {2{src[15:0]}}; end
      else exp_be = 4'b1111;
    end
    // expected load value from arithmetic on the returned word
    if (sz == 2'b00) begin
      v = (rd >> ((3 - k) * 8)) & 32'hFF;
      if (!uns && v[7]) v = v | 32'hFFFF_FF00;
    end else if (sz == 2'b01) begin
      v = (rd >> (k[1] ? 0 : 16)) & 32'hFFFF;
      if (!uns && v[15]) v = v | 32'hFFFF_0000;
    end else v = rd;
    exp_ld = (!st && !mis) ? v : 32'h0;

    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    base_addr = base; req_offset = offs; store_data = src;
    #5;
    check("R1", "mem_addr", mem_addr, ea);
    check(mis && sz != 2'b00 ? "R2" : "R2", "misalign", {31'b0, misalign}, {31'b0, mis});
    check(mis ? "R3" : rq, "mem_be", {28'b0, mem_be}, {28'b0, exp_be});
    if (st && !mis) check((sz == 2'b11) ? "R11" : "R5", "mem_wdata", mem_wdata, exp_wd);
    @(negedge clk);
    req_valid = 1'b0;
    mem_rdata = rd;
    #5;
    check(mis ? "R3" : "R9", "ld_valid", {31'b0, ld_valid}, {31'b0, (!st && !mis)});
    if (st || mis) check("R9", "ld_data idle", ld_data, 32'h0);
    else if (sz == 2'b11) check("R11", "ld_data", ld_data, exp_ld);
    else if (uns && !word) check("R8", "ld_data", ld_data, exp_ld);
    else if (!word) check("R7", "ld_data", ld_data, exp_ld);
    else check("R6", "ld_data", ld_data, exp_ld);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] bases [3];
    logic [15:0] disp  [3];
    int it;
    bases[0] = 32'h1000_0000; bases[1] = 32'h0000_0010; bases[2] = 32'hFFFF_FFF8;
    disp[0]  = 16'h0000;      disp[1]  = 16'hFFF0;      disp[2]  = 16'h7FFC;
    it = 0;
    repeat (2) @(negedge clk);
    #5;
    check("R10", "ld_valid in reset", {31'b0, ld_valid}, 32'h0);
    check("R9", "ld_data in reset", ld_data, 32'h0);
    // load requested while reset is held must not produce a result
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_size = 2'b10; base_addr = 32'h40;
    @(negedge clk);
    req_valid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    #5;
    check("R10", "ld_valid after reset-cycle load", {31'b0, ld_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int b = 0; b < 3; b++)
      for (int d = 0; d < 3; d++)
        for (int off = 0; off < 4; off++)
          for (int sz = 0; sz < 4; sz++)
            for (int u = 0; u < 2; u++)
              for (int st = 0; st < 2; st++) begin
                logic [31:0] src, rd;
                src = 32'h8F3C_A516 ^ (32'h0101_0101 * it);
                rd  = rotl(32'h9A7B_E53C, (it % 4) * 8) ^ {24'h0, 8'(it)};
                access(st[0], sz[1:0], u[0], bases[b] + off, disp[d], src, rd);
                it++;
              end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule